// File: doc/BRIEF.md
# Fetch Address Sequencer

This block holds the fetch address register and picks the address for the next cycle. Every cycle it chooses one of four sources: the straight-line step, a PC-relative branch, a region-local absolute jump or a register-indirect jump. The choice comes from decoded control strobes, and for a branch also from an equality test on two register operands.

The design is organised around a four-value selection enum. `FLOW_SEQ` is the straight-line step. `FLOW_BR` is a taken conditional branch. `FLOW_JMP` is the absolute jump inside the current region. `FLOW_JREG` is the jump through a register. The selection is recomputed every cycle from the strobes, and any selection may follow any other. The address register loads the address that the selection gives at each rising edge, unless reset is held.

The sequencer also raises a flag when an indirect jump target is not word aligned. The target is still loaded.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_q` loads the parameter `RESET_VEC` (default 0).
- R2: With no control strobe asserted, `pc_q` advances by 4 at each edge.
- R3: A taken branch loads `pc_q + 4 + (sign-extended br_off << 2)`. Offset bit 15 is the sign, so both forward and backward targets are reachable.
- R4: With `is_beq` asserted, the branch is taken only when `opnd_a == opnd_b`. Otherwise the next address is `pc_q + 4`.
- R5: With `is_bne` asserted, the branch is taken only when `opnd_a != opnd_b`. Otherwise the next address is `pc_q + 4`.
- R6: `is_jump` loads `{step[31:28], jmp_field[25:0], 2'b00}`, where `step = pc_q + 4`. This keeps the jump inside the 256 MB region of the following instruction.
- R7: `is_jreg` loads `jreg_val` unchanged into `pc_q`.
- R8: When several strobes are set, the priority is `is_jreg`, then `is_jump`, then a taken branch, then the sequential step.
- R9: `misalign_o` is combinational. It is 1 in the same cycle exactly when `is_jreg` is asserted and `jreg_val[1:0] != 0`. It is 0 whenever `is_jreg` is low, whatever `jreg_val` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| is_beq | input | 1 | Branch if operands equal |
| is_bne | input | 1 | Branch if operands differ |
| is_jump | input | 1 | Absolute jump inside the current region |
| is_jreg | input | 1 | Jump to the register value |
| opnd_a | input | 32 | First comparison operand |
| opnd_b | input | 32 | Second comparison operand |
| br_off | input | 16 | Signed word offset for branches |
| jmp_field | input | 26 | Word index for absolute jumps |
| jreg_val | input | 32 | Target for the indirect jump |
| pc_q | output | 32 | Current fetch address |
| misalign_o | output | 1 | Indirect target not word aligned |

## Verification
The bench sets `RESET_VEC` to 32'h0FFF_FFF0 and keeps the default widths. Sequential steps from that address cross the 256 MB boundary within a few cycles. A jump issued from the last word of a region must then take its upper bits from the incremented address, not from the current one. The nonzero vector also lets the bench tell a real reset load apart from a register that is merely left at zero.

// File: rtl/pcn_pkg.sv
package pcn_pkg;
    typedef enum logic [1:0] {
        FLOW_SEQ  = 2'd0,
        FLOW_BR   = 2'd1,
        FLOW_JMP  = 2'd2,
        FLOW_JREG = 2'd3
    } flow_e;
endpackage

// File: rtl/pcn_compare.sv
module pcn_compare #(
    parameter int DATA_W = 32
) (
    input  logic              want_eq,
    input  logic              want_ne,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic              taken
);
    logic same;
    always_comb begin
        same  = (lhs == rhs);
        taken = (want_eq && same) || (want_ne && !same);
    end
endmodule

// File: rtl/pcn_targets.sv
module pcn_targets #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int JTGT_W = 26
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [OFF_W-1:0]  off,
    input  logic [JTGT_W-1:0] field,
    output logic [ADDR_W-1:0] step,
    output logic [ADDR_W-1:0] br_tgt,
    output logic [ADDR_W-1:0] jmp_tgt
);
    localparam int REGION_W = ADDR_W - JTGT_W - 2;
    localparam int EXT_W    = ADDR_W - OFF_W - 2;

    logic [ADDR_W-1:0] disp;

    always_comb begin
        step    = cur + ADDR_W'(4);
        disp    = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
        br_tgt  = step + disp;
        jmp_tgt = {step[ADDR_W-1 -: REGION_W], field, 2'b00};
    end
endmodule

// File: rtl/pcn_select.sv
module pcn_select
    import pcn_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              jreg_req,
    input  logic              jump_req,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] step,
    input  logic [ADDR_W-1:0] br_tgt,
    input  logic [ADDR_W-1:0] jmp_tgt,
    input  logic [ADDR_W-1:0] reg_tgt,
    output flow_e             flow,
    output logic [ADDR_W-1:0] nxt
);
    always_comb begin
        if (jreg_req)      flow = FLOW_JREG;
        else if (jump_req) flow = FLOW_JMP;
        else if (br_taken) flow = FLOW_BR;
        else               flow = FLOW_SEQ;
    end

    always_comb begin
        unique case (flow)
            FLOW_SEQ:  nxt = step;
            FLOW_BR:   nxt = br_tgt;
            FLOW_JMP:  nxt = jmp_tgt;
            FLOW_JREG: nxt = reg_tgt;
            default:   nxt = step;
        endcase
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcn_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          OFF_W     = 16,
    parameter int          JTGT_W    = 26,
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_beq,
    input  logic              is_bne,
    input  logic              is_jump,
    input  logic              is_jreg,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    input  logic [OFF_W-1:0]  br_off,
    input  logic [JTGT_W-1:0] jmp_field,
    input  logic [ADDR_W-1:0] jreg_val,
    output logic [ADDR_W-1:0] pc_q,
    output logic              misalign_o
);
    localparam logic [ADDR_W-1:0] RST_PC = RESET_VEC[ADDR_W-1:0];

    logic              br_taken;
    logic [ADDR_W-1:0] step, br_tgt, jmp_tgt, nxt;
    flow_e             flow;

    pcn_compare #(.DATA_W(ADDR_W)) u_cmp (
        .want_eq(is_beq), .want_ne(is_bne),
        .lhs(opnd_a), .rhs(opnd_b), .taken(br_taken)
    );

    pcn_targets #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .JTGT_W(JTGT_W)) u_tgt (
        .cur(pc_q), .off(br_off), .field(jmp_field),
        .step(step), .br_tgt(br_tgt), .jmp_tgt(jmp_tgt)
    );

    pcn_select #(.ADDR_W(ADDR_W)) u_sel (
        .jreg_req(is_jreg), .jump_req(is_jump), .br_taken(br_taken),
        .step(step), .br_tgt(br_tgt), .jmp_tgt(jmp_tgt), .reg_tgt(jreg_val),
        .flow(flow), .nxt(nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RST_PC;
        else     pc_q <= nxt;
    end

    always_comb begin
        misalign_o = (flow == FLOW_JREG) && (jreg_val[1:0] != 2'b00);
    end

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_beq && !is_bne && !is_jump && !is_jreg) |=> pc_q == $past(pc_q) + ADDR_W'(4));
    // R7
    jreg_load_chk: assert property (@(posedge clk) disable iff (rst)
        is_jreg |=> pc_q == $past(jreg_val));
    // R6
    jump_form_chk: assert property (@(posedge clk) disable iff (rst)
        (is_jump && !is_jreg) |=> (pc_q[1:0] == 2'b00) && (pc_q[JTGT_W+1:2] == $past(jmp_field)));
    // R9
    misalign_src_chk: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> is_jreg);
    // R9
    misalign_next_chk: assert property (@(posedge clk) disable iff (rst)
        misalign_o |=> pc_q[1:0] != 2'b00);
endmodule

// File: tb/sim_pc_next_unit.sv
`timescale 1ns/1ps
module sim_pc_next_unit;
    localparam logic [31:0] RV = 32'h0FFF_FFF0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic is_beq = 0, is_bne = 0, is_jump = 0, is_jreg = 0;
    logic [31:0] opnd_a = 0, opnd_b = 0, jreg_val = 0;
    logic [15:0] br_off = 0;
    logic [25:0] jmp_field = 0;
    logic [31:0] pc_q;
    logic misalign_o;

    int total = 0, bad = 0;
    logic [31:0] model_pc;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    pc_next_unit #(.RESET_VEC(RV)) u0 (
        .clk, .rst, .is_beq, .is_bne, .is_jump, .is_jreg,
        .opnd_a, .opnd_b, .br_off, .jmp_field, .jreg_val,
        .pc_q, .misalign_o
    );

    function automatic logic [31:0] predict(
        logic [31:0] pc, logic eq_s, logic ne_s, logic j_s, logic jr_s,
        logic [31:0] a, logic [31:0] b, logic [15:0] off,
        logic [25:0] fld, logic [31:0] rv);
        logic [31:0] s;
        s = pc + 32'd4;
        if (jr_s) return rv;
        if (j_s) return {s[31:28], fld, 2'b00};
        if ((eq_s && a == b) || (ne_s && a != b))
            return s + {{14{off[15]}}, off, 2'b00};
        return s;
    endfunction

    // monitor: compares the register one cycle after the driver's push
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (pc_q !== e) begin
                    bad++;
                    $display("FAIL %s pc_q actual=%h expected=%h", t, pc_q, e);
                end
            end
        end
    end

    task automatic step(input logic eq_s, input logic ne_s, input logic j_s, input logic jr_s,
                        input logic [31:0] a, input logic [31:0] b, input logic [15:0] off,
                        input logic [25:0] fld, input logic [31:0] rv,
                        input string tag, input logic chk_mis, input logic exp_mis);
        logic [31:0] e;
        @(negedge clk);
        rst = 0; is_beq = eq_s; is_bne = ne_s; is_jump = j_s; is_jreg = jr_s;
        opnd_a = a; opnd_b = b; br_off = off; jmp_field = fld; jreg_val = rv;
        #1;
        if (chk_mis) begin
            total++;
            if (misalign_o !== exp_mis) begin
                bad++;
                $display("FAIL R9 misalign_o actual=%b expected=%b", misalign_o, exp_mis);
            end
        end
        e = predict(model_pc, eq_s, ne_s, j_s, jr_s, a, b, off, fld, rv);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        model_pc = e;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; is_beq = 0; is_bne = 0; is_jump = 0; is_jreg = 0;
        #1;
        exp_q.push_back(RV);
        tag_q.push_back("R1");
        model_pc = RV;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset vector
        do_reset();
        // R2: straight-line steps crossing the region boundary
        step(0,0,0,0, 0,0,0,0,0, "R2", 1, 0);
        step(0,0,0,0, 0,0,0,0,0, "R2", 0, 0);
        step(0,0,0,0, 0,0,0,0,0, "R2", 0, 0);
        // R6: jump from 0x0FFFFFFC takes region from the incremented address
        step(0,0,1,0, 0,0,0,26'h0000123,0, "R6", 0, 0);
        // R4/R3: beq equal, forward offset
        step(1,0,0,0, 32'h55,32'h55,16'h0008,0,0, "R4 R3", 0, 0);
        // R4: beq unequal
        step(1,0,0,0, 32'h55,32'h56,16'h0008,0,0, "R4", 0, 0);
        // R5/R3: bne differing, backward offset
        step(0,1,0,0, 32'h1,32'h2,16'hFFFC,0,0, "R5 R3", 0, 0);
        // R5: bne equal
        step(0,1,0,0, 32'h7,32'h7,16'hFFFC,0,0, "R5", 0, 0);
        // R7: aligned indirect
        step(0,0,0,1, 0,0,0,0,32'h0040_0020, "R7", 1, 0);
        // R9: misaligned indirect still loads
        step(0,0,0,1, 0,0,0,0,32'h0040_0023, "R9 R7", 1, 1);
        // R9: odd register value without the strobe
        step(0,0,0,0, 0,0,0,0,32'h0000_0003, "R2 R9", 1, 0);
        // R8: every strobe set
        step(1,0,1,1, 32'h9,32'h9,16'h0010,26'h3FFFFFF,32'h0000_1000, "R8", 1, 0);
        // R8: jump beats taken branch
        step(0,1,1,0, 32'h1,32'h0,16'h0010,26'h0000ABC,0, "R8", 0, 0);
        // R3: largest negative offset
        step(1,0,0,0, 0,0,16'h8000,0,0, "R3", 0, 0);
        // R1: reset mid-run
        do_reset();
        step(0,0,0,0, 0,0,0,0,0, "R2", 0, 0);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule